// File: doc/BRIEF.md
# Invalidation Queue and Fence Completion Unit

This unit sits on the cache side of a processor in a relaxed-ordering multiprocessor. Invalidation requests from the interconnect are acknowledged in the same cycle they arrive and are stored in a small FIFO. The entries are applied to the cache tag array later, one per cycle, whenever the tag port is free. The unit also contains the tag array itself, with a fill port and a combinational probe port, so that the effect of each applied invalidation can be seen.

Synchronisation operations are presented on a fence port. An acquire waits until every invalidation that was queued before it has been applied. A release waits until every write and read this processor has outstanding is complete. A full sync waits for both conditions. While a fence is pending, the unit raises a hold signal that the pipeline uses to keep later accesses from starting. When the fence finishes, the unit gives a one-cycle done pulse.

Top module: `inval_fence_unit`

## Requirements
- R1: When `inv_valid` is high and the queue has room, `inv_ack` is high in the same cycle and the address is stored in the queue at that clock edge.
- R2: When the queue holds `DEPTH` entries, `inv_ready` is low, `inv_ack` stays low even if `inv_valid` is high, and the offered address is not stored. A later drain therefore never applies it.
- R3: Stored entries are applied in arrival order, one per cycle, and only in cycles where `tag_busy` is low. An entry accepted at one edge is applied at the next edge at the earliest, so its line still probes as present after the acceptance edge.
- R4: Applying an entry clears the valid bit of the set selected by the low `SET_BITS` address bits, and only if the stored tag (the upper address bits) matches. A line in the same set with a different tag stays valid.
- R5: An acquire (`fence_kind` = 2'b01) counts the entries queued before its request edge. It completes once that many entries have been applied. Entries that arrive at or after the request edge are not waited for.
- R6: A release (`fence_kind` = 2'b10) completes at the first edge at which both the outstanding-write count (raised by `wr_issue`, lowered by `wr_done`) and the outstanding-read count (raised by `rd_issue`, lowered by `rd_done`) were already zero before that edge.
- R7: A sync (`fence_kind` = 2'b11) completes only when the acquire condition and the release condition both hold.
- R8: `fence_busy` is high from the edge that accepts a fence until the edge that completes it. A `fence_req` made while busy, or made with kind 2'b00, is ignored.
- R9: `fence_done` is a single-cycle pulse, high only in the cycle right after the completing edge. A fence whose condition already holds completes one edge after it is accepted.
- R10: After reset, `inv_ready` is high, `fence_busy` and `fence_done` are low, and no line probes as present.
- R11: A `fill_valid` pulse installs the tag of `fill_addr` as valid in its set at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Install a line in the tag array |
| fill_addr | input | AW | Block address of the line to install |
| probe_addr | input | AW | Block address to look up |
| probe_hit | output | 1 | The probed block is present and valid |
| inv_valid | input | 1 | An invalidation request is offered |
| inv_addr | input | AW | Block address to invalidate |
| inv_ready | output | 1 | The queue can take a request |
| inv_ack | output | 1 | Acknowledgement returned to the interconnect |
| tag_busy | input | 1 | Tag port taken by the pipeline; no entry is applied |
| wr_issue | input | 1 | A write has been sent to the interconnect |
| wr_done | input | 1 | Completion of an earlier write |
| rd_issue | input | 1 | A read miss has been sent out |
| rd_done | input | 1 | An earlier read has been performed |
| fence_req | input | 1 | Present a fence |
| fence_kind | input | 2 | 01 acquire, 10 release, 11 sync |
| fence_busy | output | 1 | Fence pending; later accesses are held |
| fence_done | output | 1 | One-cycle completion pulse |

## Verification
Acknowledgement is combinational, so the bench reads `inv_ack` before the edge that takes the entry. An entry is applied at the earliest one edge after it is accepted, so a probe is checked to still hit just after the acceptance edge and to miss one edge later. Fence completion always costs one edge beyond the edge where the condition is observed. An acquire with three earlier entries and a free tag port is therefore due four edges after the port frees, and a release is due one edge after the last completion. The bench counts edges from each stimulus and samples two time units after the edge, so every check lands in the exact cycle the requirement predicts.

// File: rtl/inval_fence_unit.sv
module inval_fence_unit #(
  parameter int AW       = 12,
  parameter int SET_BITS = 3,
  parameter int DEPTH    = 4,
  parameter int CNT_W    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_valid,
  input  logic [AW-1:0] fill_addr,
  input  logic [AW-1:0] probe_addr,
  output logic          probe_hit,
  input  logic          inv_valid,
  input  logic [AW-1:0] inv_addr,
  output logic          inv_ready,
  output logic          inv_ack,
  input  logic          tag_busy,
  input  logic          wr_issue,
  input  logic          wr_done,
  input  logic          rd_issue,
  input  logic          rd_done,
  input  logic          fence_req,
  input  logic [1:0]    fence_kind,
  output logic          fence_busy,
  output logic          fence_done
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = AW - SET_BITS;
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int QW    = $clog2(DEPTH + 1);

  // tag array
  logic [TAG_W-1:0] tag_q [SETS];
  logic [SETS-1:0]  vld_q;

  // invalidation FIFO
  logic [AW-1:0] q_mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [QW-1:0] q_cnt;
  logic          push, pop;

  // outstanding access counters
  logic [CNT_W-1:0] wr_cnt, rd_cnt;

  // fence state
  logic          busy_q, done_q;
  logic [1:0]    kind_q;
  logic [QW-1:0] rem_q;
  logic          accept, cond_ok;

  wire [AW-1:0]       head   = q_mem[rp_q];
  wire [SET_BITS-1:0] h_idx  = head[SET_BITS-1:0];
  wire [TAG_W-1:0]    h_tag  = head[AW-1:SET_BITS];
  wire [SET_BITS-1:0] f_idx  = fill_addr[SET_BITS-1:0];
  wire [SET_BITS-1:0] p_idx  = probe_addr[SET_BITS-1:0];

  assign probe_hit = vld_q[p_idx] && (tag_q[p_idx] == probe_addr[AW-1:SET_BITS]);
  assign inv_ready = (q_cnt != QW'(DEPTH));
  assign inv_ack   = inv_valid && inv_ready;
  assign push      = inv_ack;
  assign pop       = (q_cnt != '0) && !tag_busy;

  assign fence_busy = busy_q;
  assign fence_done = done_q;
  assign accept     = fence_req && !busy_q && (fence_kind != 2'b00);
  assign cond_ok    = (!kind_q[0] || rem_q == '0) &&
                      (!kind_q[1] || (wr_cnt == '0 && rd_cnt == '0));

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (fill_valid) tag_q[f_idx] <= fill_addr[AW-1:SET_BITS];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else begin
      if (pop && vld_q[h_idx] && tag_q[h_idx] == h_tag) vld_q[h_idx] <= 1'b0;
      if (fill_valid) vld_q[f_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) q_mem[wp_q] <= inv_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      q_cnt <= '0;
    end else begin
      if (push) wp_q <= nxt(wp_q);
      if (pop)  rp_q <= nxt(rp_q);
      q_cnt <= q_cnt + QW'(push) - QW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt <= '0;
      rd_cnt <= '0;
    end else begin
      wr_cnt <= wr_cnt + CNT_W'(wr_issue) - CNT_W'(wr_done);
      rd_cnt <= rd_cnt + CNT_W'(rd_issue) - CNT_W'(rd_done);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      kind_q <= 2'b00;
      rem_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        kind_q <= fence_kind;
        rem_q  <= q_cnt - QW'(pop);
      end else if (busy_q) begin
        if (pop && rem_q != '0) rem_q <= rem_q - QW'(1);
        if (cond_ok) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= QW'(DEPTH));

  // R1
  ack_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_ack |=> (q_cnt != '0));

  // R5
  acq_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_done && kind_q[0]) |-> $past(rem_q == '0));

  // R6
  rel_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_done && kind_q[1]) |-> $past(wr_cnt == '0 && rd_cnt == '0));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done |=> !fence_done);

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fence_busy) |-> fence_done);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done |-> wr_cnt != '0) and (rd_done |-> rd_cnt != '0));
endmodule

// File: tb/inval_fence_unit_tb_top.sv
module inval_fence_unit_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 12;

  logic clk = 0, rst_n = 0;
  logic fill_valid = 0, inv_valid = 0, tag_busy = 0;
  logic wr_issue = 0, wr_done = 0, rd_issue = 0, rd_done = 0;
  logic fence_req = 0;
  logic [1:0] fence_kind = 0;
  logic [AW-1:0] fill_addr = 0, probe_addr = 0, inv_addr = 0;
  logic probe_hit, inv_ready, inv_ack, fence_busy, fence_done;
  int total = 0, bad = 0;
  bit ended = 0;

  always #(CLK_P/2) clk = ~clk;

  inval_fence_unit dut_i (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .probe_addr(probe_addr), .probe_hit(probe_hit), .inv_valid(inv_valid),
    .inv_addr(inv_addr), .inv_ready(inv_ready), .inv_ack(inv_ack),
    .tag_busy(tag_busy), .wr_issue(wr_issue), .wr_done(wr_done),
    .rd_issue(rd_issue), .rd_done(rd_done), .fence_req(fence_req),
    .fence_kind(fence_kind), .fence_busy(fence_busy), .fence_done(fence_done));

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic check(input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic probe(input logic [AW-1:0] a, input int exp, input string what);
    probe_addr = a; #1;
    check(probe_hit, exp, what);
  endtask

  task automatic fill(input logic [AW-1:0] a);
    fill_valid = 1; fill_addr = a; step(); fill_valid = 0;
  endtask

  task automatic push(input logic [AW-1:0] a);
    inv_valid = 1; inv_addr = a; step(); inv_valid = 0;
  endtask

  task automatic t_reset();
    check(inv_ready, 1, "R10 ready after reset");
    check(fence_busy, 0, "R10 busy after reset");
    check(fence_done, 0, "R10 done after reset");
    probe(12'h000, 0, "R10 empty tags");
    probe(12'h3A5, 0, "R10 empty tags");
  endtask

  task automatic t_apply();
    fill(12'h015); fill(12'h02A);
    probe(12'h015, 1, "R11 fill installs");
    inv_valid = 1; inv_addr = 12'h015; #1;
    check(inv_ack, 1, "R1 same-cycle ack");
    step(); inv_valid = 0;
    probe(12'h015, 1, "R3 not yet applied after accept edge");
    step();
    probe(12'h015, 0, "R3 applied next edge");
    push(12'h12A); step();
    probe(12'h02A, 1, "R4 tag mismatch keeps line");
  endtask

  task automatic t_lazy();
    fill(12'h053);
    tag_busy = 1;
    push(12'h053); step(); step();
    probe(12'h053, 1, "R3 held while tag port busy");
    tag_busy = 0; step();
    probe(12'h053, 0, "R3 applied once port free");
  endtask

  task automatic t_full();
    fill(12'h031); fill(12'h032); fill(12'h033); fill(12'h034); fill(12'h035);
    tag_busy = 1;
    push(12'h031); push(12'h032); push(12'h033); push(12'h034);
    inv_valid = 1; inv_addr = 12'h035; #1;
    check(inv_ready, 0, "R2 ready low when full");
    check(inv_ack, 0, "R2 no ack when full");
    step(); inv_valid = 0; tag_busy = 0;
    for (int i = 0; i < 6; i++) step();
    probe(12'h034, 0, "R2 stored entries drained");
    probe(12'h035, 1, "R2 refused entry never applied");
  endtask

  task automatic t_acquire();
    int n;
    fill(12'h061); fill(12'h062); fill(12'h063); fill(12'h064);
    tag_busy = 1;
    push(12'h061); push(12'h062); push(12'h063);
    fence_req = 1; fence_kind = 2'b01;
    inv_valid = 1; inv_addr = 12'h064;
    step();
    fence_req = 0; inv_valid = 0;
    check(fence_busy, 1, "R8 busy after acquire accepted");
    step();
    check(fence_busy, 1, "R5 acquire waits while port busy");
    tag_busy = 0;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      step(); n++;
      if (fence_done) break;
    end
    check(n, 4, "R5 acquire edges after port frees");
    check(fence_busy, 0, "R8 busy cleared at done");
    step();
    check(fence_done, 0, "R9 done lasts one cycle");
    fence_req = 1; fence_kind = 2'b01; step(); fence_req = 0;
    check(fence_done, 0, "R9 empty acquire not done at accept");
    step();
    check(fence_done, 1, "R9 empty acquire done one edge later");
    fence_req = 1; fence_kind = 2'b00; step(); fence_req = 0;
    check(fence_busy, 0, "R8 kind 00 ignored");
  endtask

  task automatic t_release();
    wr_issue = 1; step(); step(); wr_issue = 0;
    rd_issue = 1; step(); rd_issue = 0;
    fence_req = 1; fence_kind = 2'b10; step();
    check(fence_busy, 1, "R8 release accepted");
    fence_kind = 2'b01;
    wr_done = 1; step(); fence_req = 0;
    wr_done = 0; rd_done = 1; step(); rd_done = 0;
    check(fence_busy, 1, "R6 waits for last write");
    wr_done = 1; step(); wr_done = 0;
    check(fence_done, 0, "R6 done not at completing edge");
    step();
    check(fence_done, 1, "R6 release done one edge later");
    step();
    check(fence_done, 0, "R8 request made while busy ignored");
    check(fence_busy, 0, "R8 no second fence");
  endtask

  task automatic t_sync();
    fill(12'h047);
    tag_busy = 1;
    push(12'h047);
    wr_issue = 1; step(); wr_issue = 0;
    fence_req = 1; fence_kind = 2'b11; step(); fence_req = 0;
    tag_busy = 0; step(); step(); step();
    probe(12'h047, 0, "R7 invalidation applied");
    check(fence_busy, 1, "R7 sync still waits for write");
    wr_done = 1; step(); wr_done = 0;
    check(fence_done, 0, "R7 not done at completing edge");
    step();
    check(fence_done, 1, "R7 sync done");
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1; step();
    t_reset();
    t_apply();
    t_lazy();
    t_full();
    t_acquire();
    t_release();
    t_sync();
    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule